// File: doc/BRIEF.md
# Multi-DAC Serial Write Controller

This block writes 14-bit codes into a bank of identical serial-input DACs. Every DAC shares one serial clock line and one data line, and each DAC has its own active-low chip select. The host places a request on a valid/ready handshake. The request carries a DAC index, a 16-bit data word, a bit-order flag and a load flag. The block builds a 16-bit frame, asserts the decoded chip select and shifts the frame out MSB first. The serial clock runs only during the frame. It then raises the chip select, and that rising edge latches the code in the DAC.

The serial clock comes from the system clock through a run-time divider. Each phase of the serial clock is held for `half_div_i + 1` system cycles, so one full serial-clock period T is `2*(half_div_i+1)` cycles. A host that packs its data as two bytes sent LSB first can set the bit-order flag, and the block then reverses the bits inside each byte. When the request asks for it, the block also pulses a shared active-low load strobe after the frame. A request that names a DAC which does not exist is refused with a one-cycle error flag.

Top module: `dac_burst_writer`

## Requirements
- R1: After reset, all chip selects and the load strobe are high (inactive), the serial clock, busy and error outputs are low, and ready is high.
- R2: A request is taken only while the block is idle. While busy, ready is low, and a request held valid during that time starts no frame and has no effect once the block is idle again.
- R3: A frame has exactly 16 rising serial-clock edges. The bits are sent MSB first. The first two bits sent are 0, and the last 14 bits are the code, taken from word bits 13..0 when the bit-order flag is 0.
- R4: With the bit-order flag at 1, frame bits 15..8 are word bits 8..15 in that order, and frame bits 7..0 are word bits 0..7 in that order. Frame bits 15..14 are then forced to 0.
- R5: The data line changes only while the serial clock is low. It never changes in a cycle where the serial clock is high.
- R6: For a valid index i, only chip select i goes low. It goes low in the cycle after acceptance and stays low without a break until the frame is complete.
- R7: At least one serial-clock period T passes between the chip-select fall and the first rising edge. At least T also passes between the last falling edge and the chip-select rise.
- R8: The serial clock is low whenever every chip select is high (burst clock).
- R9: The serial clock is high for half_div_i+1 cycles per pulse, and successive rising edges are 2*(half_div_i+1) cycles apart.
- R10: If the load flag is set, the load strobe goes low for exactly T cycles, starting at least T cycles after the chip-select rise, while all chip selects are high. If the load flag is clear, the load strobe stays high.
- R11: Busy rises together with the chip-select fall. It falls together with the chip-select rise, or with the end of the load pulse when a load is requested. Ready is the inverse of busy.
- R12: A request whose index is N_DAC or above drives error high for exactly one cycle, in the cycle after acceptance. It asserts no chip select and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_div_i | input | DIV_W | Serial clock half period minus one, in system cycles |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_idx_i | input | IDX_W | Target DAC index |
| req_word_i | input | FRAME_W | Data word, code in bits 13..0 |
| req_lsb_first_i | input | 1 | Word holds LSB-first bytes |
| req_load_i | input | 1 | Pulse the load strobe after the frame |
| busy_o | output | 1 | Write in progress |
| err_o | output | 1 | One-cycle pulse on an out-of-range index |
| sclk_o | output | 1 | Shared serial clock |
| sdo_o | output | 1 | Shared serial data |
| cs_no | output | N_DAC | Per-DAC chip selects, active low |
| ldac_no | output | 1 | Shared load strobe, active low |

## Verification
The bench counts the cycles of each write from the acceptance edge, with H = half_div_i+1. The chip select and busy are due one cycle after acceptance. The first rising edge is due 3H cycles later, then one rising edge every 2H cycles. The chip select rises 2H cycles after the last falling edge, and the load pulse starts 2H cycles after that and lasts 2H cycles. An error is due one cycle after acceptance. Sampling on the falling system-clock edge, the bench records the cycle of each event and checks the gaps between events. It does not check absolute times, so each check holds for any valid divider setting.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP,
    ST_LOAD
  } dbw_state_e;
endpackage

// File: rtl/dbw_tick_gen.sv
module dbw_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == half_div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !en_i)   cnt_q <= '0;
    else if (tick_o)           cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dbw_frame_pack.sv
module dbw_frame_pack #(
  parameter int CODE_W  = 14,
  parameter int BYTE_W  = 8,
  parameter int FRAME_W = 16
) (
  input  logic [FRAME_W-1:0] word_i,
  input  logic               lsb_first_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int N_BYTES = FRAME_W / BYTE_W;
  localparam int PAD_W   = FRAME_W - CODE_W;

  logic [FRAME_W-1:0] rev;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign rev[b*BYTE_W + i] = word_i[b*BYTE_W + BYTE_W-1-i];
    end
  end

  // leading pad bits are discarded by the DAC; drive them low
  always_comb begin
    frame_o = lsb_first_i ? rev : word_i;
    frame_o[FRAME_W-1 -: PAD_W] = '0;
  end
endmodule

// File: rtl/dbw_cs_decode.sv
module dbw_cs_decode #(
  parameter int N_DAC = 5,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             idx_ok_o,
  output logic [N_DAC-1:0] cs_n_o
);
  assign idx_ok_o = (32'(idx_i) < N_DAC);

  for (genvar i = 0; i < N_DAC; i++) begin : g_cs
    assign cs_n_o[i] = !(32'(idx_i) == i);
  end
endmodule

// File: rtl/dac_burst_writer.sv
module dac_burst_writer #(
  parameter int N_DAC   = 5,
  parameter int IDX_W   = $clog2(N_DAC),
  parameter int CODE_W  = 14,
  parameter int BYTE_W  = 8,
  parameter int FRAME_W = 16,
  parameter int DIV_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   half_div_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [IDX_W-1:0]   req_idx_i,
  input  logic [FRAME_W-1:0] req_word_i,
  input  logic               req_lsb_first_i,
  input  logic               req_load_i,
  output logic               busy_o,
  output logic               err_o,
  output logic               sclk_o,
  output logic               sdo_o,
  output logic [N_DAC-1:0]   cs_no,
  output logic               ldac_no
);
  import dbw_pkg::*;

  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W-1);

  dbw_state_e         state_q;
  logic               ph_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] sr_q;
  logic               sclk_q, ldac_q, err_q, load_q;
  logic [N_DAC-1:0]   cs_q;

  logic               accept, tick, idx_ok;
  logic [FRAME_W-1:0] frame;
  logic [N_DAC-1:0]   dec_cs_n;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  dbw_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (state_q != ST_IDLE),
    .clr_i      (accept),
    .half_div_i (half_div_i),
    .tick_o     (tick)
  );

  dbw_frame_pack #(.CODE_W(CODE_W), .BYTE_W(BYTE_W), .FRAME_W(FRAME_W)) u_pack (
    .word_i      (req_word_i),
    .lsb_first_i (req_lsb_first_i),
    .frame_o     (frame)
  );

  dbw_cs_decode #(.N_DAC(N_DAC), .IDX_W(IDX_W)) u_dec (
    .idx_i    (req_idx_i),
    .idx_ok_o (idx_ok),
    .cs_n_o   (dec_cs_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      bit_q   <= '0;
      sr_q    <= '0;
      sclk_q  <= 1'b0;
      ldac_q  <= 1'b1;
      err_q   <= 1'b0;
      load_q  <= 1'b0;
      cs_q    <= '1;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (idx_ok) begin
            cs_q    <= dec_cs_n;
            sr_q    <= frame;
            load_q  <= req_load_i;
            ph_q    <= 1'b0;
            bit_q   <= '0;
            state_q <= ST_LEAD;
          end else begin
            err_q <= 1'b1;
          end
        end
        // one full sclk period of setup after cs falls
        ST_LEAD: if (tick) begin
          ph_q <= !ph_q;
          if (ph_q) state_q <= ST_SHIFT;
        end
        // data moves on falling edge, DAC samples on rising
        ST_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == LAST_BIT) begin
              ph_q    <= 1'b0;
              state_q <= ST_TRAIL;
            end else begin
              sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_TRAIL: if (tick) begin
          ph_q <= !ph_q;
          if (ph_q) begin
            cs_q    <= '1;
            state_q <= load_q ? ST_GAP : ST_IDLE;
          end
        end
        ST_GAP: if (tick) begin
          ph_q <= !ph_q;
          if (ph_q) begin
            ldac_q  <= 1'b0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: if (tick) begin
          ph_q <= !ph_q;
          if (ph_q) begin
            ldac_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign err_o       = err_q;
  assign sclk_o      = sclk_q;
  assign sdo_o       = sr_q[FRAME_W-1];
  assign cs_no       = cs_q;
  assign ldac_no     = ldac_q;

  // R6
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  // R5
  sdo_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_o));
  // R8
  burst_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> !sclk_o);
  // R10
  ldac_idle_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldac_no |-> (&cs_no));
  // R12
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ((&cs_no) && !busy_o && !$past(busy_o)));
  // R2
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !busy_o);
  // R11
  cs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_no) |-> busy_o);
endmodule

// File: tb/tb_dac_burst_writer.sv
`timescale 1ns/1ps
module tb_dac_burst_writer;
  localparam int N = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_div = '0;
  logic        valid = 1'b0;
  logic [2:0]  idx_i = '0;
  logic [15:0] word = '0;
  logic        lsb_i = 1'b0, load_i = 1'b0;
  logic        ready, busy, err, sclk, sdo, ldac_n;
  logic [N-1:0] cs_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dac_burst_writer #(.N_DAC(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .half_div_i(half_div),
    .req_valid_i(valid), .req_ready_o(ready), .req_idx_i(idx_i),
    .req_word_i(word), .req_lsb_first_i(lsb_i), .req_load_i(load_i),
    .busy_o(busy), .err_o(err), .sclk_o(sclk), .sdo_o(sdo),
    .cs_no(cs_n), .ldac_no(ldac_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input logic [15:0] w, input bit lsb);
    logic [15:0] f;
    if (lsb) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 8; i++) f[b*8+i] = w[b*8+7-i];
    end else f = w;
    f[15:14] = 2'b00;
    return f;
  endfunction

  task automatic do_req(input int idx, input logic [15:0] w, input bit lsb,
                        input bit ld, input int hh);
    int cs_fall = -1, cs_rise = -1, first_rise = -1, last_rise = -1;
    int last_fall = -1, nr = 0, per_bad = 0, sdo_bad = 0, sclk_bad = 0;
    int cs_bad = 0, ld_start = -1, ld_len = 0, rdy_bad = 0, busy_end = -1;
    int post_bad = 0;
    logic [15:0] rx = '0;
    logic ps, pd;
    @(negedge clk);
    valid = 1'b1; idx_i = 3'(idx); word = w; lsb_i = lsb; load_i = ld;
    ps = sclk; pd = sdo;
    @(negedge clk);
    valid = 1'b0;
    if (idx >= N) begin
      chk(err == 1'b1, "R12", "err after bad index", int'(err), 1);
      chk(busy == 1'b0, "R12", "busy after bad index", int'(busy), 0);
      @(negedge clk);
      chk(err == 1'b0, "R12", "err pulse width", int'(err), 0);
      for (int i = 0; i < 3*hh + 4; i++) begin
        if (cs_n != '1 || sclk || busy) post_bad++;
        @(negedge clk);
      end
      chk(post_bad == 0, "R12", "activity after bad index", post_bad, 0);
      return;
    end
    for (int t = 1; t < 4000; t++) begin
      if (~cs_n != '0) begin
        if (cs_fall < 0) cs_fall = t;
        if (~cs_n != N'(1 << idx)) cs_bad++;
      end else if (cs_fall >= 0 && cs_rise < 0) cs_rise = t;
      if (sclk && !ps) begin
        if (first_rise < 0) first_rise = t;
        else if (t - last_rise != 2*hh) per_bad++;
        last_rise = t;
        rx = {rx[14:0], sdo};
        nr++;
      end
      if (!sclk && ps) begin
        last_fall = t;
        if (t - last_rise != hh) per_bad++;
      end
      if (sclk && sdo != pd) sdo_bad++;
      if (sclk && cs_n == '1) sclk_bad++;
      if (ready == busy) rdy_bad++;
      if (!ldac_n) begin
        if (ld_start < 0) ld_start = t;
        ld_len++;
        if (cs_n != '1) cs_bad++;
      end
      ps = sclk; pd = sdo;
      if (!busy) begin busy_end = t; break; end
      @(negedge clk);
      // stray request while busy must be ignored (R2)
      if (t == 10) begin valid = 1'b1; idx_i = 3'((idx + 1) % N); end
      if (t == 14) valid = 1'b0;
    end
    for (int i = 0; i < 3*hh + 4; i++) begin
      @(negedge clk);
      if (cs_n != '1 || sclk || busy) post_bad++;
    end
    chk(cs_fall == 1, "R6", "cs fall cycle", cs_fall, 1);
    chk(cs_bad == 0, "R6", "wrong or extra cs", cs_bad, 0);
    chk(nr == 16, "R3", "rising edges", nr, 16);
    chk(rx == exp_frame(w, lsb), lsb ? "R4" : "R3", "frame", int'(rx),
        int'(exp_frame(w, lsb)));
    chk(rx[15:14] == 2'b00, "R3", "pad bits", int'(rx[15:14]), 0);
    chk(sdo_bad == 0, "R5", "sdo change while sclk high", sdo_bad, 0);
    chk(first_rise - cs_fall >= 2*hh, "R7", "cs to first rise", first_rise - cs_fall, 2*hh);
    chk(cs_rise - last_fall >= 2*hh, "R7", "last fall to cs rise", cs_rise - last_fall, 2*hh);
    chk(sclk_bad == 0, "R8", "sclk outside frame", sclk_bad, 0);
    chk(per_bad == 0, "R9", "sclk timing", per_bad, 0);
    if (ld) begin
      chk(ld_len == 2*hh, "R10", "load pulse length", ld_len, 2*hh);
      chk(ld_start - cs_rise >= 2*hh, "R10", "cs rise to load", ld_start - cs_rise, 2*hh);
      chk(busy_end == ld_start + ld_len, "R11", "busy end with load", busy_end, ld_start + ld_len);
    end else begin
      chk(ld_len == 0, "R10", "load pulse absent", ld_len, 0);
      chk(busy_end == cs_rise, "R11", "busy end", busy_end, cs_rise);
    end
    chk(rdy_bad == 0, "R11", "ready vs busy", rdy_bad, 0);
    chk(post_bad == 0, "R2", "stray request started activity", post_bad, 0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == '1, "R1", "cs after reset", int'(cs_n), 31);
    chk(!sclk && !busy && !err, "R1", "sclk/busy/err after reset",
        int'({sclk, busy, err}), 0);
    chk(ldac_n && ready, "R1", "ldac/ready after reset", int'({ldac_n, ready}), 3);
    for (int d = 0; d < 2; d++) begin
      half_div = (d == 0) ? 8'd0 : 8'd2;
      for (int ix = 0; ix < 8; ix++)
        for (int lsb = 0; lsb < 2; lsb++)
          for (int ld = 0; ld < 2; ld++)
            for (int k = 0; k < 4; k++) begin
              logic [15:0] w;
              case (k)
                0: w = 16'hFFFF;
                1: w = 16'h0000;
                2: w = 16'(ix * 16'h1357 + lsb * 16'h0F0F) ^ 16'hA5C3;
                default: w = 16'(ld * 16'h3001 + ix * 16'h2AC9) ^ 16'h5A3C;
              endcase
              do_req(ix, w, lsb[0], ld[0], int'(half_div) + 1);
            end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule